// File: doc/BRIEF.md
# Parallel Drive Register Access Sequencer

This block sits on the host side of a parallel ATA (IDE) drive cable and carries out one programmed-I/O register access at a time. A local requester presents a register selection, made of a bank bit and a 3-bit offset, together with a direction and, for writes, a data word. The block then runs one bus cycle on the cable. It first asserts the chip select of the chosen bank and drives the address lines. After a set number of clock cycles it pulses the matching active-low read or write strobe. It then holds the select for a recovery period and finishes with a one-cycle completion pulse. For reads the completion pulse carries the captured data.

All phase lengths are counted in clock cycles and set by parameters, and the parameters are checked against the nanosecond minimums when the design is elaborated. The drive may stretch the strobe by pulling its channel-ready line low. A limit counter bounds how long the stretch can last and reports an error when that limit is reached. The data register at offset 0 of the primary bank is the only register that moves 16 bits. Every other register uses only the low byte. The data bus is split into an output value, an output enable and an input value, and a pad ring turns these into a tristate bus.

Top module: `pio_reg_cycle`

## Requirements
- R1: After reset both chip selects and both strobes are high (inactive), the bus output enable is 0, the completion pulse is 0, the ready-for-request output is 1 and the address-latch output is 1.
- R2: A request with bank bit 0 drives `ide_cs0_n` low and `ide_cs1_n` high. A request with bank bit 1 and offset 6 or 7 drives `ide_cs1_n` low and `ide_cs0_n` high. The two selects are never low together, and while a select is low the address lines equal the requested offset.
- R3: A request with bank bit 1 and offset 0 to 5 is rejected. The completion pulse comes with the error flag set in the cycle after acceptance. No select or strobe goes low, and the address lines keep their earlier value.
- R4: The select stays active for exactly SETUP_CYC clock cycles before the strobe falls.
- R5: A read pulses only `ide_rd_n` and a write pulses only `ide_wr_n`, and the two strobes are never low together. With channel-ready high, the strobe stays low for exactly STROBE_CYC cycles.
- R6: After the strobe rises the select stays active for exactly HOLD_CYC cycles. Then a completion pulse one cycle long is given, and during that cycle both selects are already high.
- R7: On a write the output enable is 1 and the output data is stable in every cycle that a select is active, which covers the rising edge of the write strobe. On a read, and when idle, the output enable is 0.
- R8: Offset 0 of bank 0 transfers all 16 bits. For every other register a write drives bits 15..8 as 0, and a read returns bits 15..8 as 0 and bits 7..0 from the bus.
- R9: If channel-ready is low when the minimum strobe width ends, the strobe stays low until channel-ready is sampled high, up to WAIT_LIMIT extra cycles. The access then completes with the error flag at 0.
- R10: If channel-ready is still low after WAIT_LIMIT extra strobe cycles, the strobe ends anyway. The hold phase still runs, and the completion pulse carries the error flag set to 1.
- R11: The ready-for-request output is 0 from acceptance until the completion cycle. Requests presented during that time are ignored and start no further cycle.
- R12: Between accesses the address lines keep the offset of the last accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_bank | input | 1 | 0 = primary register bank, 1 = auxiliary bank |
| req_addr | input | 3 | Register offset within the bank |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (low byte only for narrow registers) |
| req_ready | output | 1 | High when a request can be accepted |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Error flag, valid with rsp_done (rejected selection or wait timeout) |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| ide_cs0_n | output | 1 | Primary bank chip select, active low |
| ide_cs1_n | output | 1 | Auxiliary bank chip select, active low |
| ide_addr | output | 3 | Register address lines |
| ide_rd_n | output | 1 | Read strobe, active low |
| ide_wr_n | output | 1 | Write strobe, active low |
| ide_ale | output | 1 | Address latch enable, held high |
| ide_data_out | output | 16 | Value to drive on the data bus |
| ide_data_oe | output | 1 | Data bus output enable (0 = high-Z) |
| ide_data_in | input | 16 | Value sampled from the data bus |
| ide_ready | input | 1 | Channel-ready from the drive; low stretches the strobe |

## Verification
The bench builds the block with SETUP_CYC=4, STROBE_CYC=10, HOLD_CYC=2 and WAIT_LIMIT=6 on an 8 ns clock. These are the smallest counts that still meet the 25 ns and 80 ns minimums, and the small wait limit makes the stretch-versus-timeout boundary reachable in a few cycles. With these values the bench sweeps all sixteen bank/offset pairs in both directions, covering every narrow/wide and valid/rejected selection. It also steps the channel-ready release point from zero up to two cycles past the wait limit, which checks the strobe length and the error flag on both sides of the limit.

// File: rtl/pio_reg_pkg.sv
`timescale 1ns/1ps
package pio_reg_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } phase_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pio_sel_decode.sv
`timescale 1ns/1ps
module pio_sel_decode #(
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned AUX_BASE  = 6,
   parameter int unsigned AUX_NUM   = 2,
   parameter int unsigned WIDE_ADDR = 0
) (
   input  logic              bank,
   input  logic [ADDR_W-1:0] addr,
   output logic              sel_ok,
   output logic              wide
);
   localparam logic [ADDR_W-1:0] AUX_LO = ADDR_W'(AUX_BASE);
   localparam logic [ADDR_W-1:0] AUX_HI = ADDR_W'(AUX_BASE + AUX_NUM - 1);
   localparam logic [ADDR_W-1:0] WIDE_A = ADDR_W'(WIDE_ADDR);

   initial begin
      if (AUX_NUM == 0 || AUX_BASE + AUX_NUM > (1 << ADDR_W))
         $error("auxiliary window does not fit the address space");
   end

   logic aux_hit;

   generate
      if (AUX_NUM == 1) begin : g_aux_single
         assign aux_hit = (addr == AUX_LO);
      end else begin : g_aux_range
         assign aux_hit = (addr >= AUX_LO) && (addr <= AUX_HI);
      end
   endgenerate

   assign sel_ok = !bank || aux_hit;
   assign wide   = !bank && (addr == WIDE_A);

endmodule

// File: rtl/pio_phase_seq.sv
`timescale 1ns/1ps
module pio_phase_seq
   import pio_reg_pkg::*;
#(
   parameter int unsigned SETUP_CYC  = 4,
   parameter int unsigned STROBE_CYC = 10,
   parameter int unsigned HOLD_CYC   = 2,
   parameter int unsigned WAIT_LIMIT = 256
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   sel_ok,
   input  logic   ready_in,
   output phase_e phase_o,
   output logic   accept_o,
   output logic   strobe_end_o,
   output logic   done_o,
   output logic   err_o
);
   localparam int unsigned CNT_MAX = max3(SETUP_CYC, STROBE_CYC, HOLD_CYC);
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
   localparam int unsigned WAIT_W  = $clog2(WAIT_LIMIT + 1);
   localparam logic [CNT_W-1:0]  SET_LD = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0]  STR_LD = CNT_W'(STROBE_CYC - 1);
   localparam logic [CNT_W-1:0]  HLD_LD = CNT_W'(HOLD_CYC - 1);
   localparam logic [WAIT_W-1:0] WT_MAX = WAIT_W'(WAIT_LIMIT);

   phase_e            phase_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WAIT_W-1:0] wait_q;
   logic              tmo_q;
   logic              done_q;
   logic              err_q;
   logic              min_met;
   logic              give_up;

   assign accept_o     = (phase_q == PH_IDLE) && start;
   assign min_met      = (phase_q == PH_STROBE) && (cnt_q == '0);
   assign give_up      = (wait_q == WT_MAX);
   assign strobe_end_o = min_met && (ready_in || give_up);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         wait_q  <= '0;
         tmo_q   <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (start) begin
                  if (sel_ok) begin
                     phase_q <= PH_SETUP;
                     cnt_q   <= SET_LD;
                     tmo_q   <= 1'b0;
                  end else begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                  end
               end
            end
            PH_SETUP: begin
               if (cnt_q == '0) begin
                  phase_q <= PH_STROBE;
                  cnt_q   <= STR_LD;
                  wait_q  <= '0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_STROBE: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (ready_in || give_up) begin
                  phase_q <= PH_HOLD;
                  cnt_q   <= HLD_LD;
                  tmo_q   <= !ready_in;
               end else begin
                  wait_q <= wait_q + 1'b1;
               end
            end
            PH_HOLD: begin
               if (cnt_q == '0) begin
                  phase_q <= PH_IDLE;
                  done_q  <= 1'b1;
                  err_q   <= tmo_q;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase_o = phase_q;
   assign done_o  = done_q;
   assign err_o   = err_q;

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R10
   wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_STROBE) |-> (wait_q <= WT_MAX));

   // R11
   no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE) |=> !$past(accept_o));

endmodule

// File: rtl/pio_data_lane.sv
`timescale 1ns/1ps
module pio_data_lane #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned NARROW_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_wide,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              cap,
   input  logic              cur_wide,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] wdata_o,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] w_fit;
   logic [DATA_W-1:0] r_fit;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;

   generate
      if (NARROW_W >= DATA_W) begin : g_no_mask
         assign w_fit = req_wdata;
         assign r_fit = bus_in;
      end else begin : g_mask
         localparam int unsigned PAD_W = DATA_W - NARROW_W;
         assign w_fit = load_wide ? req_wdata
                                  : {{PAD_W{1'b0}}, req_wdata[NARROW_W-1:0]};
         assign r_fit = cur_wide ? bus_in
                                 : {{PAD_W{1'b0}}, bus_in[NARROW_W-1:0]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         if (load) begin
            wdata_q <= w_fit;
            rdata_q <= '0;
         end else if (cap) begin
            rdata_q <= r_fit;
         end
      end
   end

   assign wdata_o = wdata_q;
   assign rdata_o = rdata_q;

endmodule

// File: rtl/pio_reg_cycle.sv
`timescale 1ns/1ps
module pio_reg_cycle
   import pio_reg_pkg::*;
#(
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned NARROW_W      = 8,
   parameter int unsigned ADDR_W        = 3,
   parameter int unsigned AUX_BASE      = 6,
   parameter int unsigned AUX_NUM       = 2,
   parameter int unsigned CLK_PERIOD_PS = 8000,
   parameter int unsigned MIN_SETUP_PS  = 25000,
   parameter int unsigned MIN_STROBE_PS = 80000,
   parameter int unsigned SETUP_CYC     = 4,
   parameter int unsigned STROBE_CYC    = 10,
   parameter int unsigned HOLD_CYC      = 2,
   parameter int unsigned WAIT_LIMIT    = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_bank,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              ide_cs0_n,
   output logic              ide_cs1_n,
   output logic [ADDR_W-1:0] ide_addr,
   output logic              ide_rd_n,
   output logic              ide_wr_n,
   output logic              ide_ale,
   output logic [DATA_W-1:0] ide_data_out,
   output logic              ide_data_oe,
   input  logic [DATA_W-1:0] ide_data_in,
   input  logic              ide_ready
);
   initial begin
      if (SETUP_CYC * CLK_PERIOD_PS < MIN_SETUP_PS)
         $error("SETUP_CYC too short for the address setup minimum");
      if (STROBE_CYC * CLK_PERIOD_PS < MIN_STROBE_PS)
         $error("STROBE_CYC too short for the strobe width minimum");
      if (SETUP_CYC == 0 || STROBE_CYC == 0 || HOLD_CYC == 0 || WAIT_LIMIT == 0)
         $error("phase counts must be at least one");
      if (NARROW_W == 0 || NARROW_W > DATA_W)
         $error("NARROW_W must lie in 1..DATA_W");
   end

   phase_e            phase;
   logic              accept;
   logic              strobe_end;
   logic              sel_ok;
   logic              sel_wide;
   logic              bank_q;
   logic              write_q;
   logic              wide_q;
   logic [ADDR_W-1:0] addr_q;
   logic              busy;

   pio_sel_decode #(
      .ADDR_W   (ADDR_W),
      .AUX_BASE (AUX_BASE),
      .AUX_NUM  (AUX_NUM),
      .WIDE_ADDR(0)
   ) u_dec (
      .bank  (req_bank),
      .addr  (req_addr),
      .sel_ok(sel_ok),
      .wide  (sel_wide)
   );

   pio_phase_seq #(
      .SETUP_CYC (SETUP_CYC),
      .STROBE_CYC(STROBE_CYC),
      .HOLD_CYC  (HOLD_CYC),
      .WAIT_LIMIT(WAIT_LIMIT)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (req_valid),
      .sel_ok      (sel_ok),
      .ready_in    (ide_ready),
      .phase_o     (phase),
      .accept_o    (accept),
      .strobe_end_o(strobe_end),
      .done_o      (rsp_done),
      .err_o       (rsp_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q  <= 1'b0;
         write_q <= 1'b0;
         wide_q  <= 1'b0;
         addr_q  <= '0;
      end else if (accept && sel_ok) begin
         bank_q  <= req_bank;
         write_q <= req_write;
         wide_q  <= sel_wide;
         addr_q  <= req_addr;
      end
   end

   pio_data_lane #(
      .DATA_W  (DATA_W),
      .NARROW_W(NARROW_W)
   ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept && sel_ok),
      .load_wide(sel_wide),
      .req_wdata(req_wdata),
      .cap      (strobe_end && !write_q),
      .cur_wide (wide_q),
      .bus_in   (ide_data_in),
      .wdata_o  (ide_data_out),
      .rdata_o  (rsp_rdata)
   );

   assign busy        = (phase != PH_IDLE);
   assign req_ready   = !busy;
   assign ide_cs0_n   = !(busy && !bank_q);
   assign ide_cs1_n   = !(busy && bank_q);
   assign ide_addr    = addr_q;
   assign ide_rd_n    = !((phase == PH_STROBE) && !write_q);
   assign ide_wr_n    = !((phase == PH_STROBE) && write_q);
   assign ide_ale     = 1'b1;
   assign ide_data_oe = busy && write_q;

   logic cs_act;
   assign cs_act = !ide_cs0_n || !ide_cs1_n;

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ide_rd_n && !ide_wr_n));

   // R2
   cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ide_cs0_n && !ide_cs1_n));

   // R2
   strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ide_rd_n || !ide_wr_n) |-> cs_act);

   // R12
   addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && $past(cs_act)) |-> $stable(ide_addr));

   // R7
   wdata_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ide_data_oe && $past(ide_data_oe)) |-> $stable(ide_data_out));

   // R7
   oe_not_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ide_data_oe && !ide_rd_n));

   // R6
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (!cs_act && req_ready));

endmodule

// File: tb/pio_reg_cycle_tb.sv
`timescale 1ns/1ps
module pio_reg_cycle_tb_top;
   localparam int unsigned SET = 4;
   localparam int unsigned STR = 10;
   localparam int unsigned HLD = 2;
   localparam int unsigned LIM = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_bank = 1'b0;
   logic [2:0]  req_addr = '0;
   logic        req_write = 1'b0;
   logic [15:0] req_wdata = '0;
   logic        req_ready;
   logic        rsp_done;
   logic        rsp_err;
   logic [15:0] rsp_rdata;
   logic        ide_cs0_n, ide_cs1_n, ide_rd_n, ide_wr_n, ide_ale, ide_data_oe;
   logic [2:0]  ide_addr;
   logic [15:0] ide_data_out;
   logic [15:0] ide_data_in = '0;
   logic        ide_ready = 1'b1;

   int checks = 0;
   int failures = 0;
   logic [2:0] last_addr = 3'd0;

   always #4 clk = ~clk;

   pio_reg_cycle #(
      .CLK_PERIOD_PS(8000), .SETUP_CYC(SET), .STROBE_CYC(STR),
      .HOLD_CYC(HLD), .WAIT_LIMIT(LIM)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
      .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
      .req_ready(req_ready), .rsp_done(rsp_done), .rsp_err(rsp_err),
      .rsp_rdata(rsp_rdata), .ide_cs0_n(ide_cs0_n), .ide_cs1_n(ide_cs1_n),
      .ide_addr(ide_addr), .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n),
      .ide_ale(ide_ale), .ide_data_out(ide_data_out), .ide_data_oe(ide_data_oe),
      .ide_data_in(ide_data_in), .ide_ready(ide_ready)
   );

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
      end
   endtask

   task automatic run_access(input logic bk, input logic [2:0] ad, input logic wr,
                             input logic [15:0] wd, input logic [15:0] bus,
                             input int k, input bit poke);
      bit valid_sel, wide, seen_done, got_err, cs_done, bad_cs, bad_addr;
      bit bad_data, bad_dir, busy_rdy;
      logic [15:0] got_rd, exp_w, exp_r;
      int n_set, n_str, n_hold, exp_str, after;
      valid_sel = !bk || (ad >= 3'd6);
      wide      = !bk && (ad == 3'd0);
      exp_w     = wide ? wd : {8'h00, wd[7:0]};
      exp_r     = wide ? bus : {8'h00, bus[7:0]};
      exp_str   = STR + ((k > LIM) ? LIM : k);
      {seen_done, got_err, cs_done, bad_cs, bad_addr, bad_data, bad_dir, busy_rdy} = '0;
      got_rd = '0; n_set = 0; n_str = 0; n_hold = 0;
      @(negedge clk);
      req_valid = 1'b1; req_bank = bk; req_addr = ad; req_write = wr;
      req_wdata = wd; ide_data_in = bus; ide_ready = (k == 0);
      for (int it = 0; it < 200 && !seen_done; it++) begin
         @(negedge clk);
         if (it == 0) begin
            if (poke) begin
               req_bank = ~bk; req_addr = ad ^ 3'd5; req_wdata = ~wd;
            end else begin
               req_valid = 1'b0;
            end
         end
         if (rsp_done) begin
            seen_done = 1'b1; got_err = rsp_err; got_rd = rsp_rdata;
            cs_done = !ide_cs0_n || !ide_cs1_n;
            req_valid = 1'b0;
         end else begin
            if (req_ready) busy_rdy = 1'b1;
            if (ide_cs0_n && ide_cs1_n) bad_cs = 1'b1;
            else begin
               if (ide_cs0_n != bk || ide_cs1_n != !bk) bad_cs = 1'b1;
               if (ide_addr != ad) bad_addr = 1'b1;
               if (wr) begin
                  if (!ide_data_oe || ide_data_out != exp_w) bad_data = 1'b1;
               end else if (ide_data_oe) bad_data = 1'b1;
               if (!ide_rd_n || !ide_wr_n) begin
                  n_str++;
                  if (wr ? (ide_wr_n || !ide_rd_n) : (ide_rd_n || !ide_wr_n)) bad_dir = 1'b1;
                  if (n_str == STR + k) ide_ready = 1'b1;
               end else if (n_str == 0) n_set++;
               else n_hold++;
            end
         end
      end
      ide_ready = 1'b1;
      check(seen_done, "R6", "completion seen", 32'(seen_done), 1);
      if (!valid_sel) begin
         check(got_err && n_set == 0 && n_str == 0 && !bad_cs, "R3",
               "rejected selection err/no cycle", {got_err, 8'(n_set + n_str)}, 32'h100);
         check(ide_addr == last_addr, "R3", "address unchanged", 32'(ide_addr), 32'(last_addr));
      end else begin
         check(!bad_cs && !cs_done, "R2", "chip select pattern", {bad_cs, cs_done}, 0);
         check(!bad_addr, "R2", "address lines", 32'(ide_addr), 32'(ad));
         check(n_set == SET, "R4", "setup cycles", 32'(n_set), 32'(SET));
         check(n_str == exp_str && !bad_dir, "R5", "strobe cycles/direction",
               32'(n_str), 32'(exp_str));
         check(n_hold == HLD, "R6", "hold cycles", 32'(n_hold), 32'(HLD));
         check(!bad_data, "R7", "bus drive/enable", 32'(ide_data_out), 32'(exp_w));
         if (k > LIM) check(got_err, "R10", "timeout error", 32'(got_err), 1);
         else if (k > 0) check(!got_err, "R9", "stretched no error", 32'(got_err), 0);
         else check(!got_err, "R5", "no error", 32'(got_err), 0);
         if (!wr) check(got_rd == exp_r, "R8", "read data width", 32'(got_rd), 32'(exp_r));
         else check(wide || ide_data_out[15:8] == 8'h00, "R8", "narrow write upper byte",
                    32'(ide_data_out), 32'(exp_w));
         check(!busy_rdy, "R11", "ready low while busy", 32'(busy_rdy), 0);
         last_addr = ad;
      end
      after = 0;
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         if (rsp_done || !ide_cs0_n || !ide_cs1_n) after++;
      end
      check(after == 0, "R11", "no extra cycle after completion", 32'(after), 0);
      check(ide_addr == last_addr && ide_ale, "R12", "idle address hold",
            {ide_ale, 5'd0, ide_addr}, {1'b1, 5'd0, last_addr});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(ide_cs0_n && ide_cs1_n && ide_rd_n && ide_wr_n && !ide_data_oe &&
            !rsp_done && req_ready && ide_ale, "R1", "reset outputs",
            {ide_cs0_n, ide_cs1_n, ide_rd_n, ide_wr_n, ide_data_oe, rsp_done, req_ready, ide_ale},
            8'b1111_0011);
      rst_n = 1'b1;
      @(negedge clk);
      check(ide_cs0_n && ide_cs1_n && req_ready, "R1", "outputs after release",
            {ide_cs0_n, ide_cs1_n, req_ready}, 3'b111);
      for (int b = 0; b < 2; b++)
         for (int a = 0; a < 8; a++)
            for (int w = 0; w < 2; w++)
               run_access(b[0], a[2:0], w[0], 16'hA55A ^ 16'(a * 16'h1111 + b * 16'h0808 + w),
                          16'h3CC3 + 16'(a * 16'h0F01 + b * 16'h7000), 0, 1'b0);
      for (int k = 0; k <= LIM + 2; k++) begin
         run_access(1'b0, 3'd0, 1'b0, 16'h0000, 16'h8E71 + 16'(k), k, 1'b0);
         run_access(1'b1, 3'd6, 1'b1, 16'hF00D + 16'(k), 16'h0000, k, 1'b0);
      end
      run_access(1'b0, 3'd2, 1'b0, 16'h0000, 16'hBEEF, 0, 1'b1);
      run_access(1'b0, 3'd0, 1'b1, 16'h1357, 16'h0000, 2, 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog run did not finish actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule